// File: doc/BRIEF.md
# Receive Polarity Detection and Correction

This block decides whether the twisted-pair receive pair is wired in reverse and drives an invert control into the receive path. While the link is down it keeps a short history of link-pulse polarities. When the link comes up it takes its initial setting from that history. Once the link is up, valid end-of-frame delimiters can override the setting until two valid delimiters in a row agree. After that the setting is locked and detection stays disabled until the link fails again or a hard reset occurs.

The upstream link-integrity logic supplies three kinds of input. It sends one-cycle strobes for each received link pulse. It sends one-cycle strobes for entry into the link-pass state and for entry into the link-fail state. The frame decoder sends an end-of-frame strobe that carries a delimiter-valid flag and the delimiter polarity. Polarity is encoded as 0 for normal and 1 for reversed, on every input and output. All outputs are registered and change on the clock edge that samples the causing strobe.

Top module: `polarity_corrector`

## Requirements
- R1: Hard reset (rstN low, asynchronous) drives rxInvert and polReversed to 0 and locked to 0, and makes both acceptPos and acceptNeg 1.
- R2: While the link is down, link pulses are recorded in a history that holds the last HIST_LEN polarities. The history is emptied on reset and on every linkFailEvt. Pulses that arrive while the link is up are not recorded.
- R3: On linkPassEntry while the link is down, the block checks how many pulses the history has recorded. With at least HIST_LEN pulses, rxInvert becomes the majority polarity of the last HIST_LEN pulses (1 = reversed). With fewer, rxInvert keeps its value.
- R4: While the link is up, acceptPos = 1 and acceptNeg = 0 if rxInvert is 0, and acceptPos = 0 and acceptNeg = 1 if rxInvert is 1. While the link is down, both are 1.
- R5: The first valid-delimiter frame (frameEnd=1, etdValid=1) after link-up sets rxInvert to etdPol, whatever its previous value.
- R6: A later valid-delimiter frame whose etdPol differs from rxInvert sets rxInvert to etdPol and leaves locked at 0.
- R7: A valid-delimiter frame whose etdPol equals the polarity set by the previous valid frame sets locked to 1. While locked, frames and link pulses do not change rxInvert.
- R8: A frame with etdValid=0 changes neither rxInvert nor locked, and does not break the run of consecutive valid frames.
- R9: polReversed always equals rxInvert.
- R10: linkFailEvt takes the link down, clears locked and re-arms detection, and keeps rxInvert unchanged. It has priority over linkPassEntry in the same cycle.
- R11: Frames that end while the link is down have no effect on rxInvert or locked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Hard reset, active low, asynchronous |
| pulseValid | input | 1 | One-cycle strobe: a link pulse was received |
| pulsePol | input | 1 | Polarity of that pulse (1 = reversed) |
| linkPassEntry | input | 1 | One-cycle strobe: link enters the pass state |
| linkFailEvt | input | 1 | One-cycle strobe: link enters the fail state |
| frameEnd | input | 1 | One-cycle strobe: a frame ended |
| etdValid | input | 1 | The end delimiter of that frame was valid |
| etdPol | input | 1 | Polarity of that end delimiter (1 = reversed) |
| rxInvert | output | 1 | Invert control for the receive path |
| polReversed | output | 1 | Reversal status bit |
| locked | output | 1 | Polarity decision is locked |
| acceptPos | output | 1 | Normal-polarity link pulses are accepted |
| acceptNeg | output | 1 | Reversed-polarity link pulses are accepted |

## Verification
The bench builds the block with HIST_LEN set to 3 rather than the default 5. With this value a full history takes only three pulses, so the boundary between a full and a short history at link-pass entry can be reached in a few cycles. A three-deep window of mixed pulses also tests the majority vote and the shifting out of older pulses. The same stimulus table also covers a mismatch followed by a match, invalid delimiters placed between valid ones, and a link-fail strobe that arrives together with a link-pass strobe.

// File: rtl/polarity_pkg.sv
package polarity_pkg;

  typedef enum logic [1:0] {
    ST_DOWN   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_ONE    = 2'd2,
    ST_LOCKED = 2'd3
  } polState_t;

  typedef struct packed {
    logic clearHist;
    logic recordPulse;
    logic loadHist;
    logic loadFrame;
  } polStrobe_t;

endpackage

// File: rtl/polarity_history.sv
module polarity_history #(
  parameter int HIST_LEN = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic clear,
  input  logic record,
  input  logic pulsePol,
  output logic histFull,
  output logic majorityRev
);
  localparam int CNT_W = $clog2(HIST_LEN + 1);

  logic [HIST_LEN-1:0] histBits;
  logic [CNT_W-1:0]    histCnt;
  logic [CNT_W-1:0]    onesCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      histBits <= '0;
      histCnt  <= '0;
    end else if (clear) begin
      histBits <= '0;
      histCnt  <= '0;
    end else if (record) begin
      histBits <= (histBits << 1) | HIST_LEN'(pulsePol);
      if (histCnt != CNT_W'(HIST_LEN))
        histCnt <= histCnt + 1'b1;
    end
  end

  always_comb begin
    onesCnt = '0;
    for (int i = 0; i < HIST_LEN; i++)
      onesCnt = onesCnt + CNT_W'(histBits[i]);
  end

  assign histFull    = (histCnt == CNT_W'(HIST_LEN));
  assign majorityRev = (onesCnt > CNT_W'(HIST_LEN / 2));

endmodule

// File: rtl/polarity_dpath.sv
module polarity_dpath
  import polarity_pkg::*;
#(
  parameter int HIST_LEN = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  polStrobe_t strobe,
  input  logic       pulsePol,
  input  logic       etdPol,
  output logic       histFull,
  output logic       etdMatch,
  output logic       invertQ
);
  logic majorityRev;

  polarity_history #(.HIST_LEN(HIST_LEN)) u_hist (
    .clk        (clk),
    .rstN       (rstN),
    .clear      (strobe.clearHist),
    .record     (strobe.recordPulse),
    .pulsePol   (pulsePol),
    .histFull   (histFull),
    .majorityRev(majorityRev)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      invertQ <= 1'b0;
    else if (strobe.loadHist)
      invertQ <= majorityRev;
    else if (strobe.loadFrame)
      invertQ <= etdPol;
  end

  assign etdMatch = (etdPol == invertQ);

endmodule

// File: rtl/polarity_ctrl.sv
module polarity_ctrl
  import polarity_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pulseValid,
  input  logic       linkPassEntry,
  input  logic       linkFailEvt,
  input  logic       frameEnd,
  input  logic       etdValid,
  input  logic       histFull,
  input  logic       etdMatch,
  output polStrobe_t strobe,
  output logic       linkUp,
  output logic       lockedQ
);
  polState_t state, stateNext;
  logic      validFrame;

  assign validFrame = frameEnd && etdValid;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    if (linkFailEvt) begin
      strobe.clearHist = 1'b1;
      stateNext        = ST_DOWN;
    end else begin
      unique case (state)
        ST_DOWN: begin
          strobe.recordPulse = pulseValid;
          if (linkPassEntry) begin
            strobe.loadHist = histFull;
            stateNext       = ST_ARMED;
          end
        end
        ST_ARMED: begin
          if (validFrame) begin
            strobe.loadFrame = 1'b1;
            stateNext        = ST_ONE;
          end
        end
        ST_ONE: begin
          if (validFrame) begin
            if (etdMatch) stateNext = ST_LOCKED;
            else          strobe.loadFrame = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_DOWN;
    else       state <= stateNext;
  end

  assign linkUp  = (state != ST_DOWN);
  assign lockedQ = (state == ST_LOCKED);

endmodule

// File: rtl/polarity_corrector.sv
module polarity_corrector
  import polarity_pkg::*;
#(
  parameter int HIST_LEN = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic pulseValid,
  input  logic pulsePol,
  input  logic linkPassEntry,
  input  logic linkFailEvt,
  input  logic frameEnd,
  input  logic etdValid,
  input  logic etdPol,
  output logic rxInvert,
  output logic polReversed,
  output logic locked,
  output logic acceptPos,
  output logic acceptNeg
);
  polStrobe_t strobe;
  logic       histFull;
  logic       etdMatch;
  logic       linkUp;
  logic       invertQ;
  logic       lockedQ;

  polarity_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .pulseValid   (pulseValid),
    .linkPassEntry(linkPassEntry),
    .linkFailEvt  (linkFailEvt),
    .frameEnd     (frameEnd),
    .etdValid     (etdValid),
    .histFull     (histFull),
    .etdMatch     (etdMatch),
    .strobe       (strobe),
    .linkUp       (linkUp),
    .lockedQ      (lockedQ)
  );

  polarity_dpath #(.HIST_LEN(HIST_LEN)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .pulsePol(pulsePol),
    .etdPol  (etdPol),
    .histFull(histFull),
    .etdMatch(etdMatch),
    .invertQ (invertQ)
  );

  assign rxInvert    = invertQ;
  assign polReversed = invertQ;
  assign locked      = lockedQ;
  assign acceptPos   = !linkUp || !invertQ;
  assign acceptNeg   = !linkUp ||  invertQ;

endmodule

// File: rtl/polarity_corrector_chk.sv
module polarity_corrector_chk (
  input logic clk,
  input logic rstN,
  input logic linkPassEntry,
  input logic linkFailEvt,
  input logic frameEnd,
  input logic etdValid,
  input logic etdPol,
  input logic rxInvert,
  input logic locked,
  input logic acceptPos,
  input logic acceptNeg
);
  logic linkDown;
  assign linkDown = acceptPos && acceptNeg;

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> (!rxInvert && !locked && acceptPos && acceptNeg));

  assert_filter_onehot_R4: assert property (@(posedge clk) disable iff (!rstN)
    !linkDown |-> (acceptPos != acceptNeg));

  assert_frame_sets_invert_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!linkFailEvt && frameEnd && etdValid && !locked && !linkDown)
      |=> (rxInvert == $past(etdPol)));

  assert_lock_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (locked && !linkFailEvt) |=> (locked && $stable(rxInvert)));

  assert_invalid_frame_R8: assert property (@(posedge clk) disable iff (!rstN)
    (frameEnd && !etdValid && !linkPassEntry && !linkFailEvt)
      |=> ($stable(rxInvert) && $stable(locked)));

  assert_fail_rearm_R10: assert property (@(posedge clk) disable iff (!rstN)
    linkFailEvt |=> (!locked && acceptPos && acceptNeg && $stable(rxInvert)));

  assert_down_frame_R11: assert property (@(posedge clk) disable iff (!rstN)
    (linkDown && !linkPassEntry && !linkFailEvt)
      |=> ($stable(rxInvert) && !locked));

endmodule

bind polarity_corrector polarity_corrector_chk u_chk (.*);

// File: tb/polarity_corrector_tb.sv
`timescale 1ns/1ps
module polarity_corrector_tb;

  // Row bits: [10]fail [9]pass [8]pulseValid [7]pulsePol [6]frameEnd [5]etdValid [4]etdPol
  //           [3]expInvert [2]expLocked [1]expAccPos [0]expAccNeg
  localparam int NVEC = 32;
  localparam logic [10:0] VEC [0:NVEC-1] = '{
    11'b0011000_0011, // 0  R2 pulse reversed recorded
    11'b0011000_0011, // 1  R2
    11'b0011000_0011, // 2  R2 history full
    11'b0100000_1001, // 3  R3 full history -> invert, R4 filter
    11'b0000110_0010, // 4  R5 first frame overrides
    11'b0000101_0010, // 5  R8 invalid ignored
    11'b0000111_1001, // 6  R6 mismatch takes new polarity
    11'b0000100_1001, // 7  R8 invalid between valid frames
    11'b0000111_1101, // 8  R7 R8 match locks
    11'b0000110_1101, // 9  R7 locked ignores frame
    11'b1000000_1011, // 10 R10 fail keeps invert, clears lock
    11'b0000110_1011, // 11 R11 frame while down ignored
    11'b0010000_1011, // 12 R2
    11'b0010000_1011, // 13 R2
    11'b0100000_1001, // 14 R3 short history keeps invert
    11'b0000111_1001, // 15 R5
    11'b0000111_1101, // 16 R7
    11'b1100000_1011, // 17 R10 fail wins over pass
    11'b0011000_1011, // 18 R2
    11'b0010000_1011, // 19 R2
    11'b0010000_1011, // 20 R2
    11'b0100000_0010, // 21 R3 majority normal
    11'b0000110_0010, // 22 R5
    11'b0000111_1001, // 23 R6
    11'b0000110_0010, // 24 R6 no lock on alternation
    11'b0000110_0110, // 25 R7
    11'b1000000_0011, // 26 R10
    11'b0010000_0011, // 27 R2 oldest pulse shifted out later
    11'b0011000_0011, // 28 R2
    11'b0011000_0011, // 29 R2
    11'b0011000_0011, // 30 R2
    11'b0100000_1001  // 31 R3 last three reversed
  };

  logic clk = 1'b0;
  logic rstN;
  logic pulseValid, pulsePol, linkPassEntry, linkFailEvt;
  logic frameEnd, etdValid, etdPol;
  logic rxInvert, polReversed, locked, acceptPos, acceptNeg;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  polarity_corrector #(.HIST_LEN(3)) u_dut (
    .clk(clk), .rstN(rstN),
    .pulseValid(pulseValid), .pulsePol(pulsePol),
    .linkPassEntry(linkPassEntry), .linkFailEvt(linkFailEvt),
    .frameEnd(frameEnd), .etdValid(etdValid), .etdPol(etdPol),
    .rxInvert(rxInvert), .polReversed(polReversed), .locked(locked),
    .acceptPos(acceptPos), .acceptNeg(acceptNeg)
  );

  task automatic checkOut(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {rxInvert, locked, acceptPos, acceptNeg};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {inv,lock,accP,accN} actual %b expected %b", req, act, exp);
    end
    checks++;
    if (polReversed !== rxInvert) begin
      errors++;
      $display("FAIL R9: polReversed actual %b expected %b", polReversed, rxInvert);
    end
  endtask

  task automatic clearIn();
    {linkFailEvt, linkPassEntry, pulseValid, pulsePol, frameEnd, etdValid, etdPol} = '0;
  endtask

  initial begin
    clearIn();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    checkOut("R1 reset", 4'b0011);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      {linkFailEvt, linkPassEntry, pulseValid, pulsePol, frameEnd, etdValid, etdPol} = VEC[i][10:4];
      @(posedge clk);
      #1;
      clearIn();
      checkOut($sformatf("row %0d", i), VEC[i][3:0]);
    end

    // R2: pulses while link up are not recorded; after fail only 2 fresh pulses -> short history
    @(negedge clk); pulseValid = 1'b1; pulsePol = 1'b0;
    @(posedge clk); #1; clearIn();
    @(negedge clk); linkFailEvt = 1'b1;
    @(posedge clk); #1; clearIn();
    checkOut("R10 fail after up", 4'b1011);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); pulseValid = 1'b1; pulsePol = 1'b0;
      @(posedge clk); #1; clearIn();
    end
    @(negedge clk); linkPassEntry = 1'b1;
    @(posedge clk); #1; clearIn();
    checkOut("R2 R3 short history", 4'b1001);

    // R1: asynchronous hard reset from an inverted state
    @(negedge clk); rstN = 1'b0;
    #1;
    checkOut("R1 async reset", 4'b0011);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    checkOut("R1 after release", 4'b0011);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule